// File: doc/BRIEF.md
# Sprite Blitter with Colour Key, Plane Gating and Collision Flag

This block is the copy engine of a graphics add-in card that has 128 KB of local work memory, with one 8-bit pixel per byte and 17-bit local addresses. It runs one of two commands at a time. The first is a host transfer: it moves a rectangle between host memory and local memory, in either direction. Host memory is reached through a request/grant port. The second is an internal copy: it moves a rectangle from one part of local memory to another and tests each pixel as it goes.

An internal copy can apply three tests to each pixel. A colour key makes source pixels equal to the key transparent. A destination window lets a pixel be written only over destination values inside an inclusive palette range, so that palette ranges work as priority planes. A collision window raises a sticky flag whenever an opaque pixel lands on a destination value inside a second range. Every rectangle is defined by a source base, a destination base, a width, a height and one stride for each side. Pixels are visited row by row, and left to right within a row.

Top module: `sprite_blit`

## Requirements
- R1: After reset, busy and collision are 0, and neither h_req nor l_we is asserted.
- R2: A host transfer with cmd_internal=0 and cmd_to_local=1 reads host address src_base+r*src_stride+c and writes that byte, with no test applied, to local address dst_base+r*dst_stride+c (low 17 bits). This is done for every row r < height and every column c < width.
- R3: A host transfer with cmd_internal=0 and cmd_to_local=0 reads local address src_base+r*src_stride+c and writes it to host address dst_base+r*dst_stride+c, using the same rectangle walk as R2.
- R4: An internal copy (cmd_internal=1) with all tests disabled copies every source pixel of the rectangle to its destination in local memory.
- R5: In an internal copy with key_en=1, a source pixel equal to key is not written, and the destination keeps its old value.
- R6: In an internal copy with gate_en=1, a pixel is written only when the current destination value d satisfies gate_lo <= d <= gate_hi, with both bounds inclusive.
- R7: In an internal copy with coll_en=1, collision is set when a non-transparent pixel meets a destination value inside coll_lo..coll_hi (inclusive). This happens whether or not the destination window lets the write through. A transparent pixel never sets it.
- R8: collision stays set until coll_clr is high. When coll_clr is high in the same cycle as a hit, the clear wins and collision stays 0.
- R9: busy rises in the cycle after a cmd_go taken while idle, and falls once the last pixel is done. A cmd_go seen while busy has no effect.
- R10: A command with width 0 or height 0 makes no memory access, and busy stays 0.
- R11: Once h_req is raised, h_req, h_we and h_addr stay unchanged until the cycle in which h_gnt is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Command strobe |
| cmd_internal | input | 1 | 1 = internal copy, 0 = host transfer |
| cmd_to_local | input | 1 | Host transfer direction: 1 = host to local |
| src_base | input | HA_W | Source base address |
| dst_base | input | HA_W | Destination base address |
| width | input | DIM_W | Pixels per row |
| height | input | DIM_W | Number of rows |
| src_stride | input | STR_W | Source row pitch |
| dst_stride | input | STR_W | Destination row pitch |
| key_en | input | 1 | Enable colour key |
| key | input | 8 | Transparent colour |
| gate_en | input | 1 | Enable destination window |
| gate_lo | input | 8 | Destination window low bound |
| gate_hi | input | 8 | Destination window high bound |
| coll_en | input | 1 | Enable collision detection |
| coll_lo | input | 8 | Collision range low bound |
| coll_hi | input | 8 | Collision range high bound |
| coll_clr | input | 1 | Clear the collision flag |
| busy | output | 1 | Command in progress |
| collision | output | 1 | Sticky collision flag |
| h_req | output | 1 | Host access request |
| h_we | output | 1 | Host access is a write |
| h_addr | output | HA_W | Host address |
| h_wdata | output | 8 | Host write data |
| h_gnt | input | 1 | Host access done (read data valid) |
| h_rdata | input | 8 | Host read data |
| l_addr | output | LA_W | Local memory address |
| l_we | output | 1 | Local memory write enable |
| l_wdata | output | 8 | Local memory write data |
| l_rdata | input | 8 | Local read data, valid one cycle after the address |

## Verification
The table of single-pixel copies sits on each bound of both windows and one value outside it. An off-by-one comparison would then write or flag a pixel it should leave alone. Other vectors check that a transparent pixel over the collision range leaves the flag clear, and that a pixel the window blocks still flags a collision. A design that tied collision to the write enable would fail those checks. Multi-row rectangles with strides wider than the width expose a wrong row step, because pixels between the rows must stay untouched. A second strobe sent mid-command, a zero-width command, and a clear held through a colliding copy catch a design that restarts, touches memory, or lets a set beat the clear.

// File: rtl/sprite_blit.sv
module sprite_blit #(
  parameter int HA_W  = 24,
  parameter int LA_W  = 17,
  parameter int DIM_W = 10,
  parameter int STR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_go,
  input  logic             cmd_internal,
  input  logic             cmd_to_local,
  input  logic [HA_W-1:0]  src_base,
  input  logic [HA_W-1:0]  dst_base,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic [STR_W-1:0] src_stride,
  input  logic [STR_W-1:0] dst_stride,
  input  logic             key_en,
  input  logic [7:0]       key,
  input  logic             gate_en,
  input  logic [7:0]       gate_lo,
  input  logic [7:0]       gate_hi,
  input  logic             coll_en,
  input  logic [7:0]       coll_lo,
  input  logic [7:0]       coll_hi,
  input  logic             coll_clr,
  output logic             busy,
  output logic             collision,
  output logic             h_req,
  output logic             h_we,
  output logic [HA_W-1:0]  h_addr,
  output logic [7:0]       h_wdata,
  input  logic             h_gnt,
  input  logic [7:0]       h_rdata,
  output logic [LA_W-1:0]  l_addr,
  output logic             l_we,
  output logic [7:0]       l_wdata,
  input  logic [7:0]       l_rdata
);
  typedef enum logic [3:0] {IDLE, HRD, LWR, LRD, LCAP, HWR, SRD, DRD, EVAL} st_t;
  st_t st, first;

  logic             int_q, to_loc_q, key_en_q, gate_en_q, coll_en_q;
  logic [7:0]       key_q, glo_q, ghi_q, clo_q, chi_q, pix;
  logic [HA_W-1:0]  src_row, dst_row, src_a, dst_a;
  logic [DIM_W-1:0] col, row, w_q, h_q;
  logic [STR_W-1:0] sstr_q, dstr_q;
  logic             step, transp, gate_ok, coll_in, eval_c;

  assign src_a   = src_row + HA_W'(col);
  assign dst_a   = dst_row + HA_W'(col);
  assign eval_c  = (st == EVAL);
  assign transp  = key_en_q && (pix == key_q);
  assign gate_ok = !gate_en_q || (l_rdata >= glo_q && l_rdata <= ghi_q);
  assign coll_in = coll_en_q && (l_rdata >= clo_q && l_rdata <= chi_q);
  assign step    = (st == LWR) || eval_c || (st == HWR && h_gnt);
  assign first   = int_q ? SRD : (to_loc_q ? HRD : LRD);

  assign busy    = (st != IDLE);
  assign h_req   = (st == HRD) || (st == HWR);
  assign h_we    = (st == HWR);
  assign h_addr  = (st == HRD) ? src_a : dst_a;
  assign h_wdata = pix;
  assign l_addr  = (st == SRD || st == LRD) ? src_a[LA_W-1:0] : dst_a[LA_W-1:0];
  assign l_we    = (st == LWR) || (eval_c && !transp && gate_ok);
  assign l_wdata = pix;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      {int_q, to_loc_q, key_en_q, gate_en_q, coll_en_q} <= '0;
      {key_q, glo_q, ghi_q, clo_q, chi_q, pix} <= '0;
      src_row <= '0; dst_row <= '0;
      col <= '0; row <= '0; w_q <= '0; h_q <= '0;
      sstr_q <= '0; dstr_q <= '0;
    end else begin
      case (st)
        IDLE: if (cmd_go && width != '0 && height != '0) begin
          int_q <= cmd_internal; to_loc_q <= cmd_to_local;
          key_en_q <= key_en; key_q <= key;
          gate_en_q <= gate_en; glo_q <= gate_lo; ghi_q <= gate_hi;
          coll_en_q <= coll_en; clo_q <= coll_lo; chi_q <= coll_hi;
          src_row <= src_base; dst_row <= dst_base;
          w_q <= width; h_q <= height; sstr_q <= src_stride; dstr_q <= dst_stride;
          col <= '0; row <= '0;
          st <= cmd_internal ? SRD : (cmd_to_local ? HRD : LRD);
        end
        HRD:  if (h_gnt) begin pix <= h_rdata; st <= LWR; end
        LRD:  st <= LCAP;
        LCAP: begin pix <= l_rdata; st <= HWR; end
        SRD:  st <= DRD;
        DRD:  begin pix <= l_rdata; st <= EVAL; end
        default: ;
      endcase
      if (step) begin
        if (col == w_q - 1'b1) begin
          col <= '0;
          if (row == h_q - 1'b1) st <= IDLE;
          else begin
            row <= row + 1'b1;
            src_row <= src_row + HA_W'(sstr_q);
            dst_row <= dst_row + HA_W'(dstr_q);
            st <= first;
          end
        end else begin
          col <= col + 1'b1;
          st <= first;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || coll_clr) collision <= 1'b0;
    else if (eval_c && !transp && coll_in) collision <= 1'b1;
  end
endmodule

// File: rtl/sprite_blit_chk.sv
module sprite_blit_chk #(
  parameter int HA_W  = 24,
  parameter int DIM_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_go,
  input logic [DIM_W-1:0] width,
  input logic [DIM_W-1:0] height,
  input logic             busy,
  input logic             collision,
  input logic             coll_clr,
  input logic             h_req,
  input logic             h_we,
  input logic [HA_W-1:0]  h_addr,
  input logic             h_gnt,
  input logic             l_we,
  input logic             eval_c,
  input logic             transp
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!h_req && !l_we));

  p_key_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_c && transp) |-> !l_we);

  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    coll_clr |=> !collision);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (collision && !coll_clr) |=> collision);

  p_go_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && width != '0 && height != '0) |=> busy);

  p_zero_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy && (width == '0 || height == '0)) |=> !busy);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_gnt) |=> (h_req && $stable(h_we) && $stable(h_addr)));

  p_set_in_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(collision) |-> $past(eval_c));
endmodule

bind sprite_blit sprite_blit_chk #(.HA_W(HA_W), .DIM_W(DIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .width(width), .height(height),
  .busy(busy), .collision(collision), .coll_clr(coll_clr),
  .h_req(h_req), .h_we(h_we), .h_addr(h_addr), .h_gnt(h_gnt),
  .l_we(l_we), .eval_c(eval_c), .transp(transp)
);

// File: tb/sprite_blit_test.sv
`timescale 1ns/1ps
module sprite_blit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cmd_go = 0, cmd_internal = 0, cmd_to_local = 0;
  logic [23:0] src_base = 0, dst_base = 0;
  logic [9:0] width = 0, height = 0;
  logic [11:0] src_stride = 0, dst_stride = 0;
  logic key_en = 0, gate_en = 0, coll_en = 0, coll_clr = 0;
  logic [7:0] key = 8'h0F, gate_lo = 8'h40, gate_hi = 8'h7F, coll_lo = 8'h80, coll_hi = 8'h9F;
  logic busy, collision, h_req, h_we, h_gnt = 0, l_we;
  logic [23:0] h_addr;
  logic [7:0] h_wdata, h_rdata = 0, l_wdata, l_rdata = 0;
  logic [16:0] l_addr;

  sprite_blit uut (.*);

  logic [7:0] lmem [4096];
  logic [7:0] hmem [4096];
  int hcnt = 0, hold_viol = 0;
  logic hp_valid = 0;
  logic [23:0] hp_addr = 0;
  logic hp_we = 0;

  always @(posedge clk) begin
    if (l_we) lmem[l_addr[11:0]] <= l_wdata;
    l_rdata <= lmem[l_addr[11:0]];
  end

  always @(posedge clk) begin
    h_gnt <= 1'b0;
    if (h_req && !h_gnt) begin
      if (hp_valid && (h_addr != hp_addr || h_we != hp_we)) hold_viol <= hold_viol + 1;
      hp_valid <= 1'b1; hp_addr <= h_addr; hp_we <= h_we;
      if (hcnt == 2) begin
        h_gnt <= 1'b1; hcnt <= 0;
        if (h_we) hmem[h_addr[11:0]] <= h_wdata;
        else h_rdata <= hmem[h_addr[11:0]];
      end else hcnt <= hcnt + 1;
    end else hp_valid <= 1'b0;
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input logic in, input logic tl, input int sb, input int db,
                     input int w, input int h, input int ss, input int ds);
    @(negedge clk);
    cmd_internal = in; cmd_to_local = tl; src_base = 24'(sb); dst_base = 24'(db);
    width = 10'(w); height = 10'(h); src_stride = 12'(ss); dst_stride = 12'(ds);
    cmd_go = 1;
    @(negedge clk);
    cmd_go = 0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 5000 && busy; t++) @(negedge clk);
  endtask

  // {src, dst, key_en, gate_en, coll_en, expected dst, expected collision}
  localparam logic [27:0] VEC [13] = '{
    {8'h11, 8'h22, 3'b000, 8'h11, 1'b0},
    {8'h0F, 8'h22, 3'b100, 8'h22, 1'b0},
    {8'h0F, 8'h22, 3'b000, 8'h0F, 1'b0},
    {8'h11, 8'h40, 3'b010, 8'h11, 1'b0},
    {8'h11, 8'h7F, 3'b010, 8'h11, 1'b0},
    {8'h11, 8'h3F, 3'b010, 8'h3F, 1'b0},
    {8'h11, 8'h80, 3'b010, 8'h80, 1'b0},
    {8'h11, 8'h80, 3'b001, 8'h11, 1'b1},
    {8'h11, 8'h9F, 3'b001, 8'h11, 1'b1},
    {8'h11, 8'hA0, 3'b001, 8'h11, 1'b0},
    {8'h0F, 8'h85, 3'b101, 8'h85, 1'b0},
    {8'h11, 8'h85, 3'b011, 8'h85, 1'b1},
    {8'h11, 8'h85, 3'b000, 8'h11, 1'b0}
  };

  initial begin
    for (int i = 0; i < 4096; i++) begin lmem[i] = 8'hEE; hmem[i] = 8'(i * 7); end
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 collision", collision, 0);
    chk("R1 h_req", h_req, 0); chk("R1 l_we", l_we, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // Single-pixel internal copies: R4 R5 R6 R7
    for (int v = 0; v < 13; v++) begin
      lmem[12'h010] = VEC[v][27:20]; lmem[12'h020] = VEC[v][19:12];
      {key_en, gate_en, coll_en} = VEC[v][11:9];
      coll_clr = 1; @(negedge clk); coll_clr = 0;
      run(1, 0, 'h10, 'h20, 1, 1, 1, 1);
      wait_idle(); @(negedge clk);
      chk($sformatf("R4/R5/R6 pixel vec %0d", v), lmem[12'h020], VEC[v][8:1]);
      chk($sformatf("R7 collision vec %0d", v), collision, VEC[v][0]);
    end
    {key_en, gate_en, coll_en} = 3'b000;

    // R2 host to local 3x2, src stride 16, dst stride 8
    run(0, 1, 'h100, 'h200, 3, 2, 16, 8);
    chk("R9 busy after go", busy, 1);
    wait_idle(); @(negedge clk);
    for (int r = 0; r < 2; r++)
      for (int c = 0; c < 3; c++)
        chk("R2 host to local", lmem[12'h200 + r*8 + c], hmem[12'h100 + r*16 + c]);
    chk("R2 gap untouched", lmem[12'h203], 8'hEE);

    // R3 local to host 2x2
    lmem[12'h300] = 8'hA1; lmem[12'h301] = 8'hA2; lmem[12'h304] = 8'hA3; lmem[12'h305] = 8'hA4;
    run(0, 0, 'h300, 'h800, 2, 2, 4, 32);
    wait_idle(); @(negedge clk);
    chk("R3 local to host 0", hmem[12'h800], 8'hA1);
    chk("R3 local to host 1", hmem[12'h801], 8'hA2);
    chk("R3 local to host 2", hmem[12'h820], 8'hA3);
    chk("R3 local to host 3", hmem[12'h821], 8'hA4);
    chk("R3 gap untouched", hmem[12'h802], 8'(12'h802 * 7));

    // R5 multi-pixel keyed copy, row order, and R9 ignored strobe
    for (int i = 0; i < 8; i++) begin lmem[12'h400 + i] = (i % 3 == 0) ? 8'h0F : 8'(8'h50 + i); lmem[12'h500 + i] = 8'h33; end
    lmem[12'h600] = 8'h77;
    key_en = 1;
    run(1, 0, 'h400, 'h500, 4, 2, 4, 4);
    cmd_go = 1; dst_base = 24'h600; src_base = 24'h010; width = 1; height = 1;
    @(negedge clk); cmd_go = 0;
    wait_idle(); @(negedge clk);
    key_en = 0;
    for (int i = 0; i < 8; i++)
      chk("R5 keyed rect", lmem[12'h500 + i], (i % 3 == 0) ? 8'h33 : 8'h50 + i);
    chk("R9 strobe while busy ignored", lmem[12'h600], 8'h77);

    // R8 clear held through a colliding copy
    lmem[12'h010] = 8'h11; lmem[12'h020] = 8'h88; coll_en = 1; coll_clr = 1;
    run(1, 0, 'h10, 'h20, 1, 1, 1, 1);
    wait_idle(); @(negedge clk);
    chk("R8 clear wins over set", collision, 0);
    coll_clr = 0;
    lmem[12'h020] = 8'h88;
    run(1, 0, 'h10, 'h20, 1, 1, 1, 1);
    wait_idle(); repeat (3) @(negedge clk);
    chk("R8 sticky set", collision, 1);
    coll_clr = 1; @(negedge clk); coll_clr = 0;
    chk("R8 clear strobe", collision, 0);
    coll_en = 0;

    // R10 zero-size commands
    lmem[12'h700] = 8'h5A;
    run(1, 0, 'h10, 'h700, 0, 3, 1, 1);
    chk("R10 zero width busy", busy, 0);
    run(0, 1, 'h10, 'h700, 2, 0, 1, 1);
    chk("R10 zero height busy", busy, 0);
    repeat (4) @(negedge clk);
    chk("R10 no write", lmem[12'h700], 8'h5A);

    chk("R11 request held until grant", hold_viol, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule